// File: doc/BRIEF.md
# Distributed Arithmetic Twiddle Multiplier

This block forms one component of a complex product with a constant rotation
factor, `a*c - b*d`, and uses no hardware multiplier. The two signed data words
are loaded together and then fed out one bit per clock, least significant bit
first. On each clock the pair of current bits `{b, a}` addresses a four-entry
table. The table holds the possible sums of the selected coefficients and is
filled when the operation starts. A shift-add accumulator folds each table
value into a running total that is halved on every clock. On the final clock,
which carries the sign bits, the table value is subtracted.

The coefficients are fixed-point values scaled by 256 and stored in 10-bit
signed words. An index picks one of eight coefficient pairs. The exact product
is brought back to the data scale by an arithmetic right shift of 8 bits, which
rounds toward negative infinity. A radix-4 butterfly uses the block to rotate
its outputs. To get the imaginary part of a rotation, the caller passes the data
swapped or negated.

Top module: `da_twiddle_mul`

## Requirements
- R1: A synchronous active-low reset sets `done` low and `result` to 0.
- R2: A `start` sampled high while the block is idle is accepted. `done` is then high for exactly one cycle, 8 rising edges (DATA_W) after the edge that sampled `start`.
- R3: `result` equals floor((a*c - b*d) / 256). Here a = `a_in` and b = `b_in` are 8-bit two's-complement values, and (c, d) is the pair chosen by `tw_idx`.
- R4: `tw_idx` chooses (c, d) as follows: 0:(256,0), 1:(237,98), 2:(181,181), 3:(98,237), 4:(0,256), 5:(-98,237), 6:(-181,181), 7:(-237,98). These are the cosine and sine of k·22.5°, times 256, rounded.
- R5: The result is exact over the full input range. This includes -128 on either input, because the sign bit carries negative weight.
- R6: The rescale rounds down. For example, a product of -181 gives -1 and a product of 181 gives 0.
- R7: A `start` that arrives while an operation is running is ignored. Changes on `a_in`, `b_in` or `tw_idx` after the accepting edge do not affect that operation's result.
- R8: `result` keeps its value between completions. `done` is low outside its single-cycle pulse.
- R9: A new `start` is accepted in the cycle right after `done`, so operations can run back to back every DATA_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| a_in | input | 8 | Signed operand multiplied by c |
| b_in | input | 8 | Signed operand multiplied by d |
| tw_idx | input | 3 | Coefficient pair select |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Signed rescaled product, held until next completion |

## Verification
On every cycle the assertions check four things. `done` appears exactly DATA_W edges after an accepted start, and never as a stray pulse. The completed value matches a reference product computed from the operands captured at start. `result` is stable whenever `done` is low, and the reset values hold. Only the bench scenarios can show two further behaviours. Busy-time starts and operand changes must leave the result untouched, which needs deliberate stimulus during an operation. Back-to-back throughput and the rounding of small negative fractions also need chosen stimulus. The extreme values -128 and 127 probe the subtracted sign step.

// File: rtl/da_twiddle_pkg.sv
// Shared types and the coefficient pair table for the twiddle multiplier.
// Assumes coefficients fit a 10-bit signed word at a scale of 256.
package da_twiddle_pkg;
    localparam int COEF_W   = 10;
    localparam int TW_IDX_W = 3;
    localparam int TW_NUM   = 1 << TW_IDX_W;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t c_val;
        coef_t d_val;
    } coef_pair_t;

    // cos/sin of k*22.5 degrees, scaled by 256 and rounded
    function automatic coef_pair_t twiddle_pair(input logic [TW_IDX_W-1:0] idx);
        coef_pair_t p;
        case (idx)
            3'd0:    begin p.c_val =  10'sd256; p.d_val = 10'sd0;   end
            3'd1:    begin p.c_val =  10'sd237; p.d_val = 10'sd98;  end
            3'd2:    begin p.c_val =  10'sd181; p.d_val = 10'sd181; end
            3'd3:    begin p.c_val =  10'sd98;  p.d_val = 10'sd237; end
            3'd4:    begin p.c_val =  10'sd0;   p.d_val = 10'sd256; end
            3'd5:    begin p.c_val = -10'sd98;  p.d_val = 10'sd237; end
            3'd6:    begin p.c_val = -10'sd181; p.d_val = 10'sd181; end
            3'd7:    begin p.c_val = -10'sd237; p.d_val = 10'sd98;  end
            default: begin p.c_val =  10'sd0;   p.d_val = 10'sd0;   end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/da_bit_serializer.sv
// Input shift register: loads both operands together and presents their
// current bits, least significant first. Assumes shift is high for
// exactly DATA_W cycles after a load.
module da_bit_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] a_data,
    input  logic [DATA_W-1:0] b_data,
    output logic              a_bit,
    output logic              b_bit
);
    logic [DATA_W-1:0] a_sr;
    logic [DATA_W-1:0] b_sr;

    // Load operands on accept, otherwise move one bit toward the LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sr <= '0;
            b_sr <= '0;
        end else if (load) begin
            a_sr <= a_data;
            b_sr <= b_data;
        end else if (shift) begin
            a_sr <= a_sr >> 1;
            b_sr <= b_sr >> 1;
        end
    end

    // Present the bit pair for the current step
    always_comb begin
        a_bit = a_sr[0];
        b_bit = b_sr[0];
    end
endmodule

// File: rtl/da_sum_table.sv
// Four-entry table of coefficient sums, addressed by {b_bit, a_bit}.
// Entry g holds (g[0] ? c : 0) - (g[1] ? d : 0). It is filled from the
// selected pair on load and held for the whole operation.
module da_sum_table
    import da_twiddle_pkg::*;
#(
    parameter int TBL_W = COEF_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [TW_IDX_W-1:0]     tw_idx,
    input  logic [1:0]              sel,
    output logic signed [TBL_W-1:0] sum
);
    localparam int ENTRIES = 4;

    coef_pair_t              pair;
    logic signed [TBL_W-1:0] c_ext;
    logic signed [TBL_W-1:0] d_ext;
    logic signed [TBL_W-1:0] ent [ENTRIES];

    // Pick the pair and widen both coefficients
    always_comb begin
        pair  = twiddle_pair(tw_idx);
        c_ext = TBL_W'(pair.c_val);
        d_ext = TBL_W'(pair.d_val);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam bit USE_C = (g % 2) == 1;
        localparam bit USE_D = (g / 2) == 1;
        // Precompute this entry's coefficient sum at load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (load) begin
                ent[g] <= (USE_C ? c_ext : '0) - (USE_D ? d_ext : '0);
            end
        end
    end

    // Read the entry for the current bit pair
    always_comb sum = ent[sel];
endmodule

// File: rtl/da_scale_acc.sv
// Scaling accumulator: adds (or subtracts on the sign step) a table value
// to the upper part of a full-precision product, then shifts the whole
// product right by one. After DATA_W steps it holds the exact product, and
// the result register captures it shifted right by FRAC_W (rounding down).
module da_scale_acc #(
    parameter int TBL_W  = 11,
    parameter int DATA_W = 8,
    parameter int FRAC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   step,
    input  logic                   negate,
    input  logic                   finish,
    input  logic signed [TBL_W-1:0] tbl_val,
    output logic signed [TBL_W+1+DATA_W-FRAC_W-1:0] result
);
    localparam int HI_W   = TBL_W + 1;
    localparam int FULL_W = HI_W + DATA_W;
    localparam int RES_W  = FULL_W - FRAC_W;

    logic signed [HI_W-1:0]   hi;
    logic        [DATA_W-1:0] lo;
    logic signed [HI_W-1:0]   addend;
    logic signed [HI_W-1:0]   sum;
    logic signed [FULL_W-1:0] nxt;

    // Signed add of this step's weight, then halve the whole product
    always_comb begin
        addend = negate ? -HI_W'(tbl_val) : HI_W'(tbl_val);
        sum    = hi + addend;
        nxt    = $signed({sum, lo}) >>> 1;
    end

    // Running product: clear on accept, update on each step
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hi <= '0;
            lo <= '0;
        end else if (step) begin
            hi <= nxt[FULL_W-1:DATA_W];
            lo <= nxt[DATA_W-1:0];
        end
    end

    // Capture the rescaled product on the last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (finish) begin
            result <= nxt[FULL_W-1:FULL_W-RES_W];
        end
    end
endmodule

// File: rtl/da_twiddle_mul.sv
// Top level: a multiplier-free a*c - b*d against a constant twiddle pair.
// Sequences DATA_W bit-serial steps after an accepted start. The last
// step handles the sign bits. Starts that arrive while busy are ignored.
module da_twiddle_mul
    import da_twiddle_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [DATA_W-1:0]                   a_in,
    input  logic [DATA_W-1:0]                   b_in,
    input  logic [TW_IDX_W-1:0]                 tw_idx,
    output logic                                done,
    output logic signed [COEF_W+2+DATA_W-FRAC_W-1:0] result
);
    localparam int TBL_W = COEF_W + 1;
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    logic                    busy;
    logic [CNT_W-1:0]        cnt;
    logic                    accept;
    logic                    last;
    logic                    a_bit;
    logic                    b_bit;
    logic signed [TBL_W-1:0] tbl_val;

    // Accept only when idle; the last step carries the sign bits
    always_comb begin
        accept = start && !busy;
        last   = busy && (cnt == LAST_CNT);
    end

    // Step counter, busy flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                cnt <= cnt + 1'b1;
            end
        end
    end

    da_bit_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .shift  (busy),
        .a_data (a_in),
        .b_data (b_in),
        .a_bit  (a_bit),
        .b_bit  (b_bit)
    );

    da_sum_table #(.TBL_W(TBL_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .tw_idx (tw_idx),
        .sel    ({b_bit, a_bit}),
        .sum    (tbl_val)
    );

    da_scale_acc #(.TBL_W(TBL_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (busy),
        .negate  (last),
        .finish  (last),
        .tbl_val (tbl_val),
        .result  (result)
    );
endmodule

// File: rtl/da_twiddle_mul_chk.sv
// Checker for da_twiddle_mul. It watches only the ports: it models when
// done is due and computes a reference product from the captured operands.
module da_twiddle_mul_chk
    import da_twiddle_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                start,
    input logic [DATA_W-1:0]                   a_in,
    input logic [DATA_W-1:0]                   b_in,
    input logic [TW_IDX_W-1:0]                 tw_idx,
    input logic                                done,
    input logic signed [COEF_W+2+DATA_W-FRAC_W-1:0] result
);
    logic                     m_busy;
    int                       m_cnt;
    logic                     m_done;
    logic signed [DATA_W-1:0] cap_a;
    logic signed [DATA_W-1:0] cap_b;
    logic [TW_IDX_W-1:0]      cap_idx;
    coef_pair_t               cap_pair;
    int                       ref_val;

    // Port-level model of when completion is due
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_busy  <= 1'b0;
            m_cnt   <= 0;
            m_done  <= 1'b0;
            cap_a   <= '0;
            cap_b   <= '0;
            cap_idx <= '0;
        end else begin
            m_done <= 1'b0;
            if (start && !m_busy) begin
                m_busy  <= 1'b1;
                m_cnt   <= 1;
                cap_a   <= a_in;
                cap_b   <= b_in;
                cap_idx <= tw_idx;
            end else if (m_busy) begin
                if (m_cnt == DATA_W) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end
                m_cnt <= m_cnt + 1;
            end
        end
    end

    // Reference product, floor-rescaled
    always_comb begin
        cap_pair = twiddle_pair(cap_idx);
        ref_val  = (int'(cap_a) * int'(cap_pair.c_val)
                  - int'(cap_b) * int'(cap_pair.d_val)) >>> FRAC_W;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && result == '0));

    // R2
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == m_done);

    // R3
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int'(result) == ref_val);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind da_twiddle_mul da_twiddle_mul_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .a_in   (a_in),
    .b_in   (b_in),
    .tw_idx (tw_idx),
    .done   (done),
    .result (result)
);

// File: tb/da_twiddle_mul_tb.sv
module da_twiddle_mul_tb;
    localparam int DATA_W = 8;
    localparam int FRAC_W = 8;
    localparam int RES_W  = 12;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [DATA_W-1:0]        a_in = '0;
    logic [DATA_W-1:0]        b_in = '0;
    logic [2:0]               tw_idx = '0;
    logic                     done;
    logic signed [RES_W-1:0]  result;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit prev_done = 1'b0;
    int last_res = 0;
    int exp_q[$];
    int exp_cyc_q[$];
    string tag_q[$];

    da_twiddle_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .tw_idx(tw_idx), .done(done), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // R4 pair values, written from the requirement
    function automatic int coef_c(input int k);
        case (k)
            0: return 256; 1: return 237; 2: return 181; 3: return 98;
            4: return 0;   5: return -98; 6: return -181; default: return -237;
        endcase
    endfunction
    function automatic int coef_d(input int k);
        case (k)
            0: return 0;   1: return 98;  2: return 181; 3: return 237;
            4: return 256; 5: return 237; 6: return 181; default: return 98;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Driver: called at a negedge; issues one op, pushes expectations, waits out its run
    task automatic launch(input int a, input int b, input int k, input string tag);
        int p;
        a_in   = DATA_W'(a);
        b_in   = DATA_W'(b);
        tw_idx = 3'(k);
        start  = 1'b1;
        p = (a * coef_c(k) - b * coef_d(k)) >>> FRAC_W;
        exp_q.push_back(p);
        exp_cyc_q.push_back(cyc + 1 + DATA_W);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        repeat (DATA_W) @(negedge clk);
    endtask

    // Monitor: pops expectations as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                int e;
                int ec;
                string t;
                e  = exp_q.pop_front();
                ec = exp_cyc_q.pop_front();
                t  = tag_q.pop_front();
                check(int'(result) == e, t, int'(result), e);
                check(cyc == ec, "R2 done cycle", cyc, ec);
                check(!prev_done, "R8 done single cycle", int'(prev_done), 0);
                last_res = e;
            end
        end
        prev_done = done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(result == '0, "R1 result after reset", int'(result), 0);

        // R3 / R4: random operands for every index, back to back (R9)
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 6; j++) begin
                logic signed [DATA_W-1:0] ra;
                logic signed [DATA_W-1:0] rb;
                ra = DATA_W'($urandom);
                rb = DATA_W'($urandom);
                launch(int'(ra), int'(rb), k, (j == 0) ? "R4 index pair" : "R3 random R9");
            end
        end

        // R5 extreme operands
        launch(-128, -128, 3, "R5 min min");
        launch(-128, 127, 6, "R5 min max");
        launch(127, -128, 5, "R5 max min");
        launch(127, 127, 2, "R5 max max");
        launch(0, 0, 1, "R5 zero");
        launch(-128, 0, 0, "R5 min only a");

        // R6 rounding toward negative infinity
        launch(1, 0, 2, "R6 +181 floors to 0");
        launch(-1, 0, 2, "R6 -181 floors to -1");
        launch(0, 1, 2, "R6 -181 via b");
        launch(0, -1, 2, "R6 +181 via b");

        // R7 busy starts and operand changes are ignored
        a_in = 8'd100; b_in = 8'hC4; tw_idx = 3'd1; start = 1'b1;
        exp_q.push_back((100 * 237 - (-60) * 98) >>> FRAC_W);
        exp_cyc_q.push_back(cyc + 1 + DATA_W);
        tag_q.push_back("R7 busy start ignored");
        @(negedge clk);
        for (int i = 0; i < DATA_W - 1; i++) begin
            a_in = DATA_W'($urandom); b_in = DATA_W'($urandom);
            tw_idx = 3'($urandom); start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);

        // R8 result holds after completion, done stays low
        repeat (5) @(negedge clk);
        check(int'(result) == last_res, "R8 result held", int'(result), last_res);
        check(done == 1'b0, "R8 done low while idle", int'(done), 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
        finish_run();
    end
endmodule